// File: doc/BRIEF.md
# Per-Line RGB Checksum Appender

This block sits in the transmit path of a parallel video stream made of three 8-bit colour channels (red, green, blue) qualified by a data-enable. While data-enable is high, it keeps a separate ones-complement sum for each channel over the pixels of the current line. When the line's active data ends, it can place the three checksums into the outgoing stream as a one-cycle trailer. A downstream checker can then verify each line channel by channel.

Every input is registered once. The output stream therefore always lags the input by one pixel clock, whether or not the feature is on. When the enable input is low, the stream passes through unchanged, and no trailer is inserted.

Top module: `rgbck_line_cksum`

## Requirements
- R1: While rst_n is low at a clock edge, all outputs (channel bytes, de_out, ck_vld) are 0 after that edge.
- R2: If cksum_en was low in the previous cycle, the outputs equal the previous cycle's inputs (channel bytes and de_in), and ck_vld is 0.
- R3: With cksum_en high, every active pixel (de_in high) appears at the outputs unchanged one cycle later with de_out high.
- R4: Each channel's checksum is an independent 8-bit ones-complement sum of that channel's bytes over the line. Any carry out of bit 7 is added back into bit 0 (for example, 0xFF plus 0x01 gives 0x01).
- R5: The transmitted checksum byte on each channel is the bitwise inverse of that channel's sum. A receiver that adds the line's bytes and the checksum byte therefore gets 0xFF.
- R6: A line starts when de_in goes from low to high. The sums restart at that pixel, so a checksum never includes pixels from an earlier line.
- R7: A trailer is inserted only if cksum_en is high in the first cycle with de_in low after a line. In that case, the output in the following cycle carries the three checksums on r_out, g_out and b_out, with de_out 0 and ck_vld 1. Otherwise, that cycle passes through as in R2.
- R8: A line of a single pixel gives, on each channel, a checksum equal to the inverse of that pixel's byte.
- R9: ck_vld is never high for two consecutive cycles, and never high together with de_out. A line that starts right after a one-cycle gap still has its first pixel output directly after the trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cksum_en | input | 1 | Enables trailer insertion |
| de_in | input | 1 | Input data-enable (active pixel) |
| r_in | input | 8 | Red channel byte in |
| g_in | input | 8 | Green channel byte in |
| b_in | input | 8 | Blue channel byte in |
| r_out | output | 8 | Red byte or red checksum out |
| g_out | output | 8 | Green byte or green checksum out |
| b_out | output | 8 | Blue byte or blue checksum out |
| de_out | output | 1 | Output data-enable |
| ck_vld | output | 1 | High in the cycle carrying the checksums |

## Verification
The embedded assertions check the following on every cycle:
- disabled pass-through with a one-cycle delay;
- the sum holding steady outside active data;
- the sum reloading at a line start;
- the trailer never touching de_out and never lasting two cycles;
- the trailer never appearing while disabled.

Only the bench scenarios can show that the checksum values are correct. These scenarios cover wraparound carries, the restart between lines, single-pixel lines, back-to-back lines with a one-cycle gap, and the enable dropping exactly in the cycle a line ends.

// File: rtl/rgbck_pkg.sv
// Shared constants, types and the ones-complement adder for the checksum appender.
// Assumes 8-bit channels; channel index 2 is red, 1 is green, 0 is blue.
package rgbck_pkg;
    parameter int PIX_W  = 8;
    parameter int NUM_CH = 3;
    localparam int CH_R = 2;
    localparam int CH_G = 1;
    localparam int CH_B = 0;

    typedef logic [PIX_W-1:0] pix_t;

    // Ones-complement add: the carry out of the top bit is folded back into bit 0.
    function automatic pix_t oc_add(input pix_t a, input pix_t b);
        logic [PIX_W:0] raw;
        raw = {1'b0, a} + {1'b0, b};
        return raw[PIX_W-1:0] + {{(PIX_W-1){1'b0}}, raw[PIX_W]};
    endfunction
endpackage

// File: rtl/rgbck_line_ctl.sv
// Line boundary detector: remembers the previous data-enable and flags the first
// active pixel of a line and the first blank cycle after it.
// Assumes de_in is synchronous to clk.
module rgbck_line_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic de_in,
    output logic line_start,
    output logic line_end
);
    logic de_q;

    // Hold the previous cycle's data-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) de_q <= 1'b0;
        else        de_q <= de_in;
    end

    // Decode the boundaries from the current and previous data-enable.
    always_comb begin
        line_start = de_in & ~de_q;
        line_end   = ~de_in & de_q;
    end

    // R6
    line_edges_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_start && line_end));
    // R9
    no_double_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> !line_end);
endmodule

// File: rtl/rgbck_chan_acc.sv
// One channel's running ones-complement sum. It reloads with the first pixel of a
// line, accumulates while data-enable stays high, and holds otherwise.
// Assumes line_start comes from the same data-enable that qualifies pix.
module rgbck_chan_acc
    import rgbck_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic de_in,
    input  logic line_start,
    input  pix_t pix,
    output pix_t acc
);
    // Reload on a new line, add during active data, hold while blank.
    always_ff @(posedge clk) begin
        if (!rst_n)          acc <= '0;
        else if (line_start) acc <= pix;
        else if (de_in)      acc <= oc_add(acc, pix);
    end

    // R6
    acc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (acc == $past(pix)));
    // R4
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_in |=> $stable(acc));
endmodule

// File: rtl/rgbck_out_stage.sv
// Output register: passes the stream with a one-cycle delay, or substitutes the
// inverted sums for one cycle after a line ends when insertion is enabled.
// Assumes the sums are final in the cycle line_end is high.
module rgbck_out_stage
    import rgbck_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cksum_en,
    input  logic              de_in,
    input  logic              line_end,
    input  pix_t [N-1:0]      pix_in,
    input  pix_t [N-1:0]      sums,
    output pix_t [N-1:0]      pix_out,
    output logic              de_out,
    output logic              ck_vld
);
    logic insert;

    // Decide whether this cycle becomes the trailer.
    always_comb insert = line_end & cksum_en;

    // Register either the live pixel or the inverted checksums.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out <= '0;
            de_out  <= 1'b0;
            ck_vld  <= 1'b0;
        end else if (insert) begin
            for (int i = 0; i < N; i++) pix_out[i] <= ~sums[i];
            de_out  <= 1'b0;
            ck_vld  <= 1'b1;
        end else begin
            pix_out <= pix_in;
            de_out  <= de_in;
            ck_vld  <= 1'b0;
        end
    end

    // R2
    bypass_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cksum_en)) |->
            (pix_out == $past(pix_in) && de_out == $past(de_in) && !ck_vld));
    // R7
    trailer_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ck_vld) |-> $past(cksum_en));
    // R9
    trailer_no_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck_vld |-> !de_out);
    // R9
    trailer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ck_vld |=> !ck_vld);
endmodule

// File: rtl/rgbck_line_cksum.sv
// Top of the per-line RGB checksum appender. It detects line boundaries, keeps one
// ones-complement sum per colour channel, and inserts the inverted sums as a
// one-cycle trailer after each line when cksum_en is high.
// Assumes one pixel per clock and a synchronous active-low reset.
module rgbck_line_cksum
    import rgbck_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cksum_en,
    input  logic       de_in,
    input  logic [7:0] r_in,
    input  logic [7:0] g_in,
    input  logic [7:0] b_in,
    output logic [7:0] r_out,
    output logic [7:0] g_out,
    output logic [7:0] b_out,
    output logic       de_out,
    output logic       ck_vld
);
    logic                line_start;
    logic                line_end;
    pix_t [NUM_CH-1:0]   pix_in;
    pix_t [NUM_CH-1:0]   sums;
    pix_t [NUM_CH-1:0]   pix_out;

    // Pack the channels into one indexed vector.
    always_comb begin
        pix_in[CH_R] = r_in;
        pix_in[CH_G] = g_in;
        pix_in[CH_B] = b_in;
    end

    rgbck_line_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .de_in      (de_in),
        .line_start (line_start),
        .line_end   (line_end)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rgbck_chan_acc u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .de_in      (de_in),
            .line_start (line_start),
            .pix        (pix_in[c]),
            .acc        (sums[c])
        );
    end

    rgbck_out_stage #(.N(NUM_CH)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cksum_en (cksum_en),
        .de_in    (de_in),
        .line_end (line_end),
        .pix_in   (pix_in),
        .sums     (sums),
        .pix_out  (pix_out),
        .de_out   (de_out),
        .ck_vld   (ck_vld)
    );

    // Unpack the output vector onto the channel ports.
    always_comb begin
        r_out = pix_out[CH_R];
        g_out = pix_out[CH_G];
        b_out = pix_out[CH_B];
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (de_out == 1'b0 && ck_vld == 1'b0));
endmodule

// File: tb/tb_rgbck_line_cksum.sv
`timescale 1ns/1ps
module tb_rgbck_line_cksum;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cksum_en = 1'b0;
    logic       de_in = 1'b0;
    logic [7:0] r_in = '0, g_in = '0, b_in = '0;
    logic [7:0] r_out, g_out, b_out;
    logic       de_out, ck_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] r, g, b;
        logic       de, vld;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Bench model state.
    logic       m_prev_de = 1'b0;
    logic [7:0] m_sr = '0, m_sg = '0, m_sb = '0;

    always #2 clk = ~clk;

    rgbck_line_cksum dut (
        .clk(clk), .rst_n(rst_n), .cksum_en(cksum_en), .de_in(de_in),
        .r_in(r_in), .g_in(g_in), .b_in(b_in),
        .r_out(r_out), .g_out(g_out), .b_out(b_out),
        .de_out(de_out), .ck_vld(ck_vld)
    );

    function automatic logic [7:0] ocs(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'(a) + int'(b);
        if (s > 255) s = s - 255;
        return 8'(s);
    endfunction

    // Driver: applies one cycle of input and queues the output expected after the next edge.
    task automatic drive(input logic en, input logic de, input logic [7:0] r,
                         input logic [7:0] g, input logic [7:0] b, input string tag);
        exp_t e;
        @(negedge clk);
        cksum_en = en; de_in = de; r_in = r; g_in = g; b_in = b;
        if (m_prev_de && !de && en) begin
            e.r = ~m_sr; e.g = ~m_sg; e.b = ~m_sb; e.de = 1'b0; e.vld = 1'b1;
        end else begin
            e.r = r; e.g = g; e.b = b; e.de = de; e.vld = 1'b0;
        end
        e.tag = tag;
        q.push_back(e);
        if (de && !m_prev_de) begin
            m_sr = r; m_sg = g; m_sb = b;
        end else if (de) begin
            m_sr = ocs(m_sr, r); m_sg = ocs(m_sg, g); m_sb = ocs(m_sb, b);
        end
        m_prev_de = de;
    endtask

    // Monitor: compares the outputs just after each edge against the queued item.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (r_out !== e.r || g_out !== e.g || b_out !== e.b ||
                de_out !== e.de || ck_vld !== e.vld) begin
                failures++;
                $display("FAIL %s: got r=%h g=%h b=%h de=%b vld=%b exp r=%h g=%h b=%h de=%b vld=%b",
                         e.tag, r_out, g_out, b_out, de_out, ck_vld,
                         e.r, e.g, e.b, e.de, e.vld);
            end
        end
    end

    task automatic blank(input logic en, input int n, input string tag);
        for (int i = 0; i < n; i++) drive(en, 1'b0, 8'h5A, 8'hA5, 8'h3C, tag);
    endtask

    initial begin
        // R1: reset with busy inputs
        cksum_en = 1'b1; de_in = 1'b1; r_in = 8'hFF; g_in = 8'h11; b_in = 8'h22;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (r_out !== 8'h00 || g_out !== 8'h00 || b_out !== 8'h00 || de_out !== 1'b0 || ck_vld !== 1'b0) begin
            failures++;
            $display("FAIL R1: got r=%h g=%h b=%h de=%b vld=%b exp all zero",
                     r_out, g_out, b_out, de_out, ck_vld);
        end
        de_in = 1'b0; cksum_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: disabled line passes through, no trailer
        blank(1'b0, 2, "R2");
        drive(1'b0, 1'b1, 8'h10, 8'h20, 8'h30, "R2");
        drive(1'b0, 1'b1, 8'hF0, 8'h02, 8'h81, "R2");
        drive(1'b0, 1'b1, 8'h0F, 8'hFE, 8'h7F, "R2");
        blank(1'b0, 3, "R2");

        // R3 R4 R5: enabled line with end-around carries (FF+01 -> 01)
        drive(1'b1, 1'b1, 8'hFF, 8'h80, 8'h00, "R3");
        drive(1'b1, 1'b1, 8'h01, 8'h80, 8'h00, "R4");
        drive(1'b1, 1'b1, 8'hFE, 8'h7F, 8'h01, "R4");
        drive(1'b1, 1'b1, 8'h03, 8'hC0, 8'hFF, "R3");
        blank(1'b1, 1, "R5");
        blank(1'b1, 2, "R9");

        // R6: next line must not include earlier pixels
        drive(1'b1, 1'b1, 8'h12, 8'h34, 8'h56, "R6");
        drive(1'b1, 1'b1, 8'h21, 8'h43, 8'h65, "R6");
        blank(1'b1, 1, "R6");
        blank(1'b1, 1, "R9");

        // R8: single-pixel line
        drive(1'b1, 1'b1, 8'hC3, 8'h00, 8'hFF, "R8");
        blank(1'b1, 1, "R8");
        blank(1'b1, 1, "R9");

        // R7: enable dropped exactly in the end cycle, then raised again
        drive(1'b1, 1'b1, 8'h44, 8'h55, 8'h66, "R7");
        drive(1'b1, 1'b1, 8'h01, 8'h02, 8'h03, "R7");
        drive(1'b0, 1'b0, 8'h99, 8'h88, 8'h77, "R7");
        blank(1'b1, 2, "R7");
        // R7: enable raised only in the end cycle still inserts
        drive(1'b0, 1'b1, 8'h09, 8'h08, 8'h07, "R7");
        drive(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, "R7");
        blank(1'b1, 1, "R7");

        // R9: back-to-back lines separated by a one-cycle gap
        drive(1'b1, 1'b1, 8'hAA, 8'hBB, 8'hCC, "R9");
        drive(1'b1, 1'b1, 8'h55, 8'h44, 8'h33, "R9");
        drive(1'b1, 1'b0, 8'hEE, 8'hEE, 8'hEE, "R9");
        drive(1'b1, 1'b1, 8'h80, 8'h81, 8'h82, "R9");
        drive(1'b1, 1'b1, 8'h80, 8'h7F, 8'h7E, "R4");
        blank(1'b1, 1, "R5");
        blank(1'b1, 2, "R9");

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule